// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the fetch side of a transmit DMA. It keeps a ring of transmit descriptors in its own register array. Each descriptor holds a 64-bit buffer address and a length/status word. Software writes descriptors through a simple write port and then moves a 16-bit producer index forward. While the consumer index trails the producer and both enable bits are set, the engine takes the descriptor in slot `consumer mod NUM_DESC` and issues one read request for the buffer. It forwards the returned bytes on a byte stream, with start and end markers and an append-CRC sideband. It then increments the consumer index.

The consumer index is free running and is never cleared except by the block reset. To start from a clean state, software sets the producer index equal to the current consumer value. Clearing the global enable lets the descriptor in flight run to completion, and after that no further descriptor is fetched.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset the consumer index is 0, `tx_valid` is low and no read request is pending.
- R2: Write map: descriptor slot s, word w is at address s*4+w, where w=0 is the length/status word, w=1 the low address word and w=2 the high address word. The control register is at NUM_DESC*4, with bit 0 as the global enable and bit 1 as the ring enable. The producer index is at NUM_DESC*4+1, in bits 15:0.
- R3: A descriptor is fetched only when both enable bits are 1 and the consumer index differs from the producer index.
- R4: The read request carries address {high word, low word} and the length field, which is bits 27:16 of the status word. Valid, address and length stay stable until `rd_req_ready` is seen.
- R5: Every response byte accepted for the current descriptor appears on `tx_data` with `tx_valid`, in order. A descriptor produces exactly its length in bytes.
- R6: `tx_sop` marks the first byte of a descriptor when status bit 13 is set. `tx_eop` marks its last byte when status bit 14 is set. Neither marker appears otherwise.
- R7: On every byte of a descriptor with both bit 13 and bit 14 set, `tx_crc_append` equals status bit 6. On every other byte it is 0.
- R8: The consumer index increments by exactly 1 after each descriptor and wraps at 16 bits. Index NUM_DESC reuses slot 0.
- R9: When the global enable is cleared while a descriptor is being sent, that descriptor completes and no further descriptor is fetched until the enable is set again.
- R10: A descriptor of length 0 issues no request and sends no bytes, yet the consumer index still advances.
- R11: Toggling the enables and writing the producer index equal to the consumer index leave the consumer index unchanged and start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cons_idx | output | 16 | Current consumer index |
| rd_req_valid | output | 1 | Buffer read request valid |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 64 | Buffer byte address |
| rd_req_len | output | 12 | Buffer length in bytes |
| rd_rsp_valid | input | 1 | Response byte valid |
| rd_rsp_data | input | 8 | Response byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of a frame |
| tx_eop | output | 1 | Last byte of a frame |
| tx_crc_append | output | 1 | Ask the MAC to append CRC for this frame |

## Verification
The assertions assume that the memory side returns exactly the requested number of bytes, only after a request has been accepted. They also assume that software never moves the producer more than NUM_DESC entries ahead of the consumer. The bench responder models that memory: it waits a programmable number of cycles before raising ready, then streams exactly `rd_req_len` bytes and nothing more. The bench writes the producer only forward, by at most 250 entries beyond the consumer, and never rewrites a descriptor that is still pending.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int IDX_W   = 16;
    localparam int LEN_W   = 12;
    localparam int LEN_LSB = 16;
    localparam int EOP_BIT = 14;
    localparam int SOP_BIT = 13;
    localparam int CRC_BIT = 6;

    typedef struct packed {
        logic [63:0]      addr;
        logic [LEN_W-1:0] len;
        logic             sop;
        logic             eop;
        logic             crc_app;
    } txd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_DATA,
        ST_DONE
    } txr_state_e;

    // Apply a length/status word to a stored descriptor.
    function automatic txd_t apply_status(txd_t d, logic [31:0] w);
        txd_t r;
        r         = d;
        r.len     = w[LEN_LSB +: LEN_W];
        r.sop     = w[SOP_BIT];
        r.eop     = w[EOP_BIT];
        r.crc_app = w[CRC_BIT];
        return r;
    endfunction

endpackage

// File: rtl/txr_desc_ring.sv
module txr_desc_ring import txr_pkg::*; #(
    parameter int NUM_DESC = 256,
    localparam int SLOT_W  = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [1:0]        wr_word,
    input  logic [31:0]       wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output txd_t              rd_desc
);

    txd_t slots [NUM_DESC];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            case (wr_word)
                2'd0: slots[wr_slot] <= apply_status(slots[wr_slot], wr_data);
                2'd1: slots[wr_slot].addr[31:0]  <= wr_data;
                2'd2: slots[wr_slot].addr[63:32] <= wr_data;
                default: ;
            endcase
        end
    end

    assign rd_desc = slots[rd_slot];

endmodule

// File: rtl/txr_index.sv
module txr_index import txr_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [1:0]       ctrl_data,
    input  logic             prod_we,
    input  logic [IDX_W-1:0] prod_data,
    input  logic             advance,
    output logic [IDX_W-1:0] cons,
    output logic             run,
    output logic             pending
);

    logic             glob_en_q;
    logic             ring_en_q;
    logic [IDX_W-1:0] prod_q;
    logic [IDX_W-1:0] cons_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en_q <= 1'b0;
            ring_en_q <= 1'b0;
            prod_q    <= '0;
            cons_q    <= '0;
        end else begin
            if (ctrl_we) begin
                glob_en_q <= ctrl_data[0];
                ring_en_q <= ctrl_data[1];
            end
            if (prod_we)
                prod_q <= prod_data;
            if (advance)
                cons_q <= cons_q + 1'b1;
        end
    end

    assign cons    = cons_q;
    assign run     = glob_en_q & ring_en_q;
    assign pending = (cons_q != prod_q);

    // R8: the consumer only ever steps by one, and only while work was pending
    assert_cons_step_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(cons_q) |-> (cons_q == $past(cons_q) + 16'd1) && $past(cons_q != prod_q));

endmodule

// File: rtl/txr_fetch.sv
module txr_fetch import txr_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pending,
    input  txd_t             desc,
    output logic             advance,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [63:0]      rd_req_addr,
    output logic [LEN_W-1:0] rd_req_len,
    input  logic             rd_rsp_valid,
    input  logic [7:0]       rd_rsp_data,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_sop,
    output logic             tx_eop,
    output logic             tx_crc_append
);

    txr_state_e       st;
    txd_t             cur;
    logic [LEN_W-1:0] cnt;
    logic             beat;
    logic             last_beat;

    assign beat      = (st == ST_DATA) && rd_rsp_valid;
    assign last_beat = (cnt == cur.len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cur <= '0;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (run && pending) begin
                    cur <= desc;
                    st  <= (desc.len == '0) ? ST_DONE : ST_REQ;
                end
                ST_REQ: if (rd_req_ready) begin
                    cnt <= '0;
                    st  <= ST_DATA;
                end
                ST_DATA: if (rd_rsp_valid) begin
                    cnt <= cnt + 1'b1;
                    if (last_beat)
                        st <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid      <= 1'b0;
            tx_data       <= '0;
            tx_sop        <= 1'b0;
            tx_eop        <= 1'b0;
            tx_crc_append <= 1'b0;
        end else begin
            tx_valid      <= beat;
            tx_data       <= beat ? rd_rsp_data : 8'h00;
            tx_sop        <= beat && (cnt == '0) && cur.sop;
            tx_eop        <= beat && last_beat && cur.eop;
            tx_crc_append <= beat && cur.sop && cur.eop && cur.crc_app;
        end
    end

    assign advance      = (st == ST_DONE);
    assign rd_req_valid = (st == ST_REQ);
    assign rd_req_addr  = cur.addr;
    assign rd_req_len   = cur.len;

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=>
            rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len));

    assert_no_empty_req_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> rd_req_len != '0);

    assert_start_gated_R3: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) && $past(st == ST_IDLE) |-> $past(run && pending));

    assert_marks_qualified_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_sop || tx_eop || tx_crc_append) |-> tx_valid);

endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring import txr_pkg::*; #(
    parameter int NUM_DESC = 256,
    localparam int SLOT_W  = $clog2(NUM_DESC),
    localparam int ADDR_W  = SLOT_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [15:0]       cons_idx,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [63:0]       rd_req_addr,
    output logic [11:0]       rd_req_len,
    input  logic              rd_rsp_valid,
    input  logic [7:0]        rd_rsp_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic              tx_crc_append
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_DESC * 4);
    localparam logic [ADDR_W-1:0] PROD_ADDR = ADDR_W'(NUM_DESC * 4 + 1);

    logic             desc_we;
    logic             ctrl_we;
    logic             prod_we;
    logic             advance;
    logic             run;
    logic             pending;
    logic [IDX_W-1:0] cons;
    txd_t             head_desc;

    assign desc_we = cfg_we && !cfg_addr[ADDR_W-1];
    assign ctrl_we = cfg_we && (cfg_addr == CTRL_ADDR);
    assign prod_we = cfg_we && (cfg_addr == PROD_ADDR);

    txr_desc_ring #(.NUM_DESC(NUM_DESC)) u_ring (
        .clk     (clk),
        .wr_en   (desc_we),
        .wr_slot (cfg_addr[ADDR_W-2:2]),
        .wr_word (cfg_addr[1:0]),
        .wr_data (cfg_wdata),
        .rd_slot (cons[SLOT_W-1:0]),
        .rd_desc (head_desc)
    );

    txr_index u_index (
        .clk       (clk),
        .rst       (rst),
        .ctrl_we   (ctrl_we),
        .ctrl_data (cfg_wdata[1:0]),
        .prod_we   (prod_we),
        .prod_data (cfg_wdata[IDX_W-1:0]),
        .advance   (advance),
        .cons      (cons),
        .run       (run),
        .pending   (pending)
    );

    txr_fetch u_fetch (
        .clk           (clk),
        .rst           (rst),
        .run           (run),
        .pending       (pending),
        .desc          (head_desc),
        .advance       (advance),
        .rd_req_valid  (rd_req_valid),
        .rd_req_ready  (rd_req_ready),
        .rd_req_addr   (rd_req_addr),
        .rd_req_len    (rd_req_len),
        .rd_rsp_valid  (rd_rsp_valid),
        .rd_rsp_data   (rd_rsp_data),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .tx_sop        (tx_sop),
        .tx_eop        (tx_eop),
        .tx_crc_append (tx_crc_append)
    );

    assign cons_idx = cons;

endmodule

// File: tb/tx_desc_ring_tb.sv
module tx_desc_ring_tb;

    localparam int NUM_DESC  = 256;
    localparam int ADDR_W    = $clog2(NUM_DESC) + 3;
    localparam int CTRL_A    = NUM_DESC * 4;
    localparam int PROD_A    = NUM_DESC * 4 + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [15:0]       cons_idx;
    logic              rd_req_valid;
    logic              rd_req_ready = 1'b0;
    logic [63:0]       rd_req_addr;
    logic [11:0]       rd_req_len;
    logic              rd_rsp_valid = 1'b0;
    logic [7:0]        rd_rsp_data = '0;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_sop;
    logic              tx_eop;
    logic              tx_crc_append;

    int checks = 0;
    int fails  = 0;
    int rsp_wait = 0;
    int req_count = 0;
    logic [63:0] last_addr = '0;
    logic [11:0] last_len = '0;
    bit done = 0;

    logic [7:0] mq_data [$];
    bit         mq_sop  [$];
    bit         mq_eop  [$];
    bit         mq_crc  [$];

    always #4 clk = ~clk;

    tx_desc_ring #(.NUM_DESC(NUM_DESC)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cons_idx(cons_idx), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_crc_append(tx_crc_append)
    );

    // memory responder: optional wait, accept, then exactly len bytes
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && rd_req_valid) begin
                repeat (rsp_wait) @(negedge clk);
                rd_req_ready = 1'b1;
                last_addr = rd_req_addr;
                last_len  = rd_req_len;
                req_count++;
                @(negedge clk);
                rd_req_ready = 1'b0;
                for (int i = 0; i < int'(last_len); i++) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = last_addr[7:0] + 8'(i);
                    @(negedge clk);
                end
                rd_rsp_valid = 1'b0;
            end
        end
    end

    // stream monitor
    initial begin
        forever begin
            @(negedge clk);
            if (tx_valid) begin
                mq_data.push_back(tx_data);
                mq_sop.push_back(tx_sop);
                mq_eop.push_back(tx_eop);
                mq_crc.push_back(tx_crc_append);
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = ADDR_W'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_desc(input int slot, input logic [63:0] addr, input int len,
                            input bit sop, input bit eop, input bit crc);
        logic [31:0] ls;
        ls = 32'h0000_8000;              // ownership bit set, ignored by the engine
        ls[27:16] = 12'(len);
        ls[14] = eop;
        ls[13] = sop;
        ls[6]  = crc;
        wr(slot * 4 + 1, addr[31:0]);
        wr(slot * 4 + 2, addr[63:32]);
        wr(slot * 4 + 0, ls);
    endtask

    task automatic wait_cons(input int target);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (cons_idx == 16'(target)) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_mon();
        mq_data.delete(); mq_sop.delete(); mq_eop.delete(); mq_crc.delete();
    endtask

    task automatic check_beats(input string tag, input int start, input int n, input logic [7:0] base,
                               input bit sop_exp, input bit eop_exp, input bit crc_exp);
        for (int i = 0; i < n; i++) begin
            if (start + i >= mq_data.size()) begin
                check({tag, " missing byte"}, 64'(start + i), 64'(mq_data.size()));
                break;
            end
            check({tag, " data"}, 64'(mq_data[start + i]), 64'(base + 8'(i)));
            check({tag, " sop"},  64'(mq_sop[start + i]),  64'(sop_exp && i == 0));
            check({tag, " eop"},  64'(mq_eop[start + i]),  64'(eop_exp && i == n - 1));
            check({tag, " crc"},  64'(mq_crc[start + i]),  64'(crc_exp));
        end
    endtask

    task automatic t_reset();
        check("R1 cons after reset", 64'(cons_idx), 64'd0);
        check("R1 tx_valid after reset", 64'(tx_valid), 64'd0);
        check("R1 req after reset", 64'(rd_req_valid), 64'd0);
    endtask

    task automatic t_single();
        clear_mon();
        rsp_wait = 0;
        put_desc(0, 64'h0000_0012_3456_7810, 8, 1, 1, 1);
        wr(PROD_A, 32'd1);
        wr(CTRL_A, 32'd3);
        wait_cons(1);
        check("R2 R4 request address", last_addr, 64'h0000_0012_3456_7810);
        check("R4 request length", 64'(last_len), 64'd8);
        check("R5 byte count", 64'(mq_data.size()), 64'd8);
        check_beats("R5 R6 R7 single", 0, 8, 8'h10, 1, 1, 1);
        check("R8 cons after one", 64'(cons_idx), 64'd1);
    endtask

    task automatic t_enable_gate();
        int r0;
        clear_mon();
        wr(CTRL_A, 32'd1);
        put_desc(1, 64'h0000_0000_0000_2040, 4, 1, 1, 0);
        wr(PROD_A, 32'd2);
        r0 = req_count;
        repeat (40) @(negedge clk);
        check("R3 ring enable off: cons", 64'(cons_idx), 64'd1);
        check("R3 ring enable off: requests", 64'(req_count), 64'(r0));
        wr(CTRL_A, 32'd2);
        repeat (40) @(negedge clk);
        check("R3 global enable off: cons", 64'(cons_idx), 64'd1);
        check("R3 global enable off: bytes", 64'(mq_data.size()), 64'd0);
        wr(CTRL_A, 32'd3);
        wait_cons(2);
        check("R3 both enables: cons", 64'(cons_idx), 64'd2);
        check_beats("R3 gated frame", 0, 4, 8'h40, 1, 1, 0);
    endtask

    task automatic t_multi();
        clear_mon();
        rsp_wait = 3;
        put_desc(2, 64'h0000_0000_0000_0050, 5, 1, 0, 1);
        put_desc(3, 64'h0000_0000_0000_0090, 3, 0, 1, 1);
        wr(PROD_A, 32'd4);
        wait_cons(4);
        check("R4 stalled request length", 64'(last_len), 64'd3);
        check("R5 two-part byte count", 64'(mq_data.size()), 64'd8);
        check_beats("R6 R7 first part", 0, 5, 8'h50, 1, 0, 0);
        check_beats("R6 R7 last part", 5, 3, 8'h90, 0, 1, 0);
        check("R8 cons after two", 64'(cons_idx), 64'd4);
        rsp_wait = 0;
    endtask

    task automatic t_zero();
        int r0;
        clear_mon();
        r0 = req_count;
        put_desc(4, 64'h0000_0000_0000_0070, 0, 1, 1, 1);
        wr(PROD_A, 32'd5);
        wait_cons(5);
        check("R10 zero length cons", 64'(cons_idx), 64'd5);
        check("R10 zero length requests", 64'(req_count), 64'(r0));
        check("R10 zero length bytes", 64'(mq_data.size()), 64'd0);
    endtask

    task automatic t_stop();
        int r0;
        clear_mon();
        r0 = req_count;
        put_desc(5, 64'h0000_0000_0000_0000, 24, 1, 1, 0);
        put_desc(6, 64'h0000_0000_0000_00A0, 4, 1, 1, 1);
        wr(PROD_A, 32'd7);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mq_data.size() > 0) break;
        end
        wr(CTRL_A, 32'd2);
        repeat (100) @(negedge clk);
        check("R9 in-flight frame completes", 64'(mq_data.size()), 64'd24);
        check("R9 fetch stops: cons", 64'(cons_idx), 64'd6);
        check("R9 fetch stops: requests", 64'(req_count), 64'(r0 + 1));
        check_beats("R9 finished frame", 0, 24, 8'h00, 1, 1, 0);
        wr(CTRL_A, 32'd3);
        wait_cons(7);
        check("R9 resume cons", 64'(cons_idx), 64'd7);
        check_beats("R9 resumed frame", 24, 4, 8'hA0, 1, 1, 1);
    endtask

    task automatic t_align();
        int r0;
        clear_mon();
        r0 = req_count;
        wr(CTRL_A, 32'd0);
        wr(CTRL_A, 32'd3);
        wr(PROD_A, 32'(cons_idx));
        repeat (30) @(negedge clk);
        check("R11 cons kept", 64'(cons_idx), 64'd7);
        check("R11 no request", 64'(req_count), 64'(r0));
        check("R11 no bytes", 64'(mq_data.size()), 64'd0);
    endtask

    task automatic t_wrap();
        int r0;
        clear_mon();
        r0 = req_count;
        put_desc(0, 64'h0000_0001_0000_00C0, 3, 1, 1, 1);
        for (int s = 7; s < NUM_DESC; s++)
            wr(s * 4, 32'h0000_0000);
        wr(PROD_A, 32'(NUM_DESC + 1));
        wait_cons(NUM_DESC + 1);
        check("R8 cons past ring size", 64'(cons_idx), 64'(NUM_DESC + 1));
        check("R8 R10 one request after wrap", 64'(req_count), 64'(r0 + 1));
        check("R8 slot 0 reused address", last_addr, 64'h0000_0001_0000_00C0);
        check("R8 wrapped byte count", 64'(mq_data.size()), 64'd3);
        check_beats("R8 wrapped frame", 0, 3, 8'hC0, 1, 1, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_enable_gate();
        t_multi();
        t_zero();
        t_stop();
        t_align();
        t_wrap();
        done = 1;
        summary();
    end

endmodule